// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned operands one bit at a time. A one-cycle start request while the block is idle captures a multiplier and a multiplicand. The product accumulator clears and the block raises busy. On every busy cycle it looks at the low bit of the remaining multiplier. When that bit is set, it adds the shifted multiplicand into the accumulator. It then moves the multiplicand one place up and the multiplier one place down.

The operation ends as soon as no set bits remain in the multiplier, or at the latest after one step per multiplier bit. The latency therefore follows the position of the highest set multiplier bit. Small multipliers return quickly, and a zero multiplier takes a single step. Completion is marked by a single-cycle done pulse. The product then holds until the next accepted start.

The asynchronous active-low reset is resynchronised inside the block, so its release takes effect on a clock edge.

Top module: `shift_add_mul`

## Requirements
- R1: While reset is applied, and after it is released with no start, busy_o and done_o are 0 and product_o is 0.
- R2: A start_i that is high at a rising edge while busy_o is 0 is accepted. After that edge busy_o is 1 and product_o is 0.
- R3: When done_o is 1, product_o equals the unsigned product of the accepted operands, zero-extended to 32 bits.
- R4: For a nonzero multiplier, busy_o stays high for exactly p+1 cycles, where p is the index of the highest set bit (bit 0 is the least significant). This is never more than 16 cycles.
- R5: A zero multiplier keeps busy_o high for exactly one cycle and yields a product of 0.
- R6: done_o is high for exactly one cycle, the cycle right after the last busy cycle, and it is never high together with busy_o.
- R7: While busy_o is 0 and no start is accepted, product_o holds its value.
- R8: A start_i raised while busy_o is 1 has no effect: the result and the latency are those of the operation already running.
- R9: A start_i raised in the same cycle as done_o is accepted as a new operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin an operation |
| mplier_i | input | 16 | Multiplier operand, sampled on acceptance |
| mcand_i | input | 16 | Multiplicand operand, sampled on acceptance |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| product_o | output | 32 | Product; valid from done_o until the next accepted start |

## Verification
Suppose an operation is accepted at rising edge 0. Busy is then due on the first falling edge after it, together with a cleared product. It must stay high on exactly as many consecutive falling edges as the multiplier's highest set bit index plus one; a zero multiplier counts as one. On the falling edge after that, done and the finished product are due. The edge after that must show done low with the product unchanged. The bench drives every input on falling edges and samples on falling edges. Each cycle count is compared with that arithmetic, and each product with a multiplication computed in the bench. The sweep covers every highest-bit position from 0 to 15 and zero against several multiplicand patterns. It also includes back-to-back starts issued in the done cycle and starts injected in mid-operation.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;

endpackage

// File: rtl/mul_rst_sync.sv
module mul_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int MPLIER_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rest_zero_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CNT_W = (MPLIER_W > 1) ? $clog2(MPLIER_W) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(MPLIER_W - 1);

  mul_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             finish;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign finish = step_o && (rest_zero_i || (cnt_q == LAST_STEP));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = finish;
    if (load_o) begin
      state_d = ST_RUN;
      cnt_d   = '0;
    end else if (step_o) begin
      cnt_d = cnt_q + 1'b1;
      if (finish) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = step_o;
  assign done_o = done_q;

endmodule

// File: rtl/mul_acc.sv
module mul_acc #(
  parameter int PROD_W = 32
) (
  input  logic              add_en_i,
  input  logic [PROD_W-1:0] acc_i,
  input  logic [PROD_W-1:0] addend_i,
  output logic [PROD_W-1:0] sum_o
);

  logic [PROD_W-1:0] gated;

  assign gated = addend_i & {PROD_W{add_en_i}};
  assign sum_o = acc_i + gated;

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int MPLIER_W = 16,
  parameter int MCAND_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_i,
  input  logic                          step_i,
  input  logic [MPLIER_W-1:0]           mplier_i,
  input  logic [MCAND_W-1:0]            mcand_i,
  output logic                          rest_zero_o,
  output logic [MPLIER_W+MCAND_W-1:0]   product_o
);

  localparam int PROD_W = MPLIER_W + MCAND_W;

  logic [MPLIER_W-1:0] mr_q, mr_d;
  logic [PROD_W-1:0]   md_q, md_d;
  logic [PROD_W-1:0]   prod_q, prod_d;
  logic [PROD_W-1:0]   sum;

  mul_acc #(.PROD_W(PROD_W)) u_acc (
    .add_en_i (mr_q[0]),
    .acc_i    (prod_q),
    .addend_i (md_q),
    .sum_o    (sum)
  );

  always_comb begin
    mr_d   = mr_q;
    md_d   = md_q;
    prod_d = prod_q;
    if (load_i) begin
      mr_d   = mplier_i;
      md_d   = {{MPLIER_W{1'b0}}, mcand_i};
      prod_d = '0;
    end else if (step_i) begin
      mr_d   = mr_q >> 1;
      md_d   = md_q << 1;
      prod_d = sum;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr_q   <= '0;
      md_q   <= '0;
      prod_q <= '0;
    end else if (load_i || step_i) begin
      mr_q   <= mr_d;
      md_q   <= md_d;
      prod_q <= prod_d;
    end
  end

  generate
    if (MPLIER_W > 1) begin : g_rest
      assign rest_zero_o = ~|mr_q[MPLIER_W-1:1];
    end else begin : g_rest1
      assign rest_zero_o = 1'b1;
    end
  endgenerate

  assign product_o = prod_q;

endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int MPLIER_W = 16,
  parameter int MCAND_W  = 16,
  parameter int PROD_W   = MPLIER_W + MCAND_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [MPLIER_W-1:0] mplier_i,
  input  logic [MCAND_W-1:0]  mcand_i,
  output logic                busy_o,
  output logic                done_o,
  output logic [PROD_W-1:0]   product_o
);

  logic rst_n_sync;
  logic load, step, rest_zero;

  mul_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_n_sync)
  );

  mul_ctrl #(.MPLIER_W(MPLIER_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .start_i     (start_i),
    .rest_zero_i (rest_zero),
    .load_o      (load),
    .step_o      (step),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  mul_datapath #(.MPLIER_W(MPLIER_W), .MCAND_W(MCAND_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .load_i      (load),
    .step_i      (step),
    .mplier_i    (mplier_i),
    .mcand_i     (mcand_i),
    .rest_zero_o (rest_zero),
    .product_o   (product_o)
  );

endmodule

// File: rtl/mul_checker.sv
module mul_checker #(
  parameter int MPLIER_W = 16,
  parameter int PROD_W   = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [PROD_W-1:0] product_o
);

  localparam int RUN_W = $clog2(MPLIER_W + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (busy_o) run_q <= run_q + 1'b1;
    else             run_q <= '0;
  end

  assert_busy_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (run_q < RUN_W'(MPLIER_W)));

  assert_load_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> (busy_o && product_o == '0));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && busy_o));

  assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(product_o));

endmodule

bind shift_add_mul mul_checker #(.MPLIER_W(MPLIER_W), .PROD_W(PROD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .start_i   (start_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .product_o (product_o)
);

// File: tb/shift_add_mul_test.sv
module shift_add_mul_test;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [15:0] mplier_i;
  logic [15:0] mcand_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] product_o;

  int n_chk;
  int n_bad;
  logic [15:0] lfsr;

  shift_add_mul uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .mplier_i  (mplier_i),
    .mcand_i   (mcand_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [15:0] b);
    int p;
    p = 0;
    for (int i = 0; i < 16; i++) if (b[i]) p = i;
    return p + 1;
  endfunction

  function automatic logic [15:0] step_lfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // Entered on a falling edge; leaves on the falling edge where done is seen.
  task automatic run_op(input logic [15:0] b, input logic [15:0] a, input bit poke);
    int lat;
    int guard;
    lat = 0;
    guard = 0;
    start_i  = 1'b1;
    mplier_i = b;
    mcand_i  = a;
    @(negedge clk);
    start_i = 1'b0;
    check("R2 busy after start", {31'd0, busy_o}, 32'd1);
    check("R2 product cleared", product_o, 32'd0);
    while (busy_o && guard < 40) begin
      lat++;
      guard++;
      if (poke && lat == 1) begin
        start_i  = 1'b1;
        mplier_i = ~b;
        mcand_i  = ~a;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    if (b == 16'd0) check("R5 zero latency", lat, 32'd1);
    else            check("R4 latency", lat, exp_lat(b));
    if (poke) check("R8 latency unchanged", lat, exp_lat(b));
    check("R6 done pulse", {31'd0, done_o}, 32'd1);
    check("R3 product", product_o, {16'd0, a} * {16'd0, b});
    if (poke) check("R8 product unchanged", product_o, {16'd0, a} * {16'd0, b});
  endtask

  task automatic idle_check(input logic [31:0] exp);
    @(negedge clk);
    check("R6 done single", {31'd0, done_o}, 32'd0);
    check("R7 hold", product_o, exp);
    @(negedge clk);
    @(negedge clk);
    check("R7 hold idle", product_o, exp);
    check("R7 not busy", {31'd0, busy_o}, 32'd0);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    lfsr = 16'hACE1;
    rst_n = 1'b0;
    start_i = 1'b0;
    mplier_i = '0;
    mcand_i = '0;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", {31'd0, busy_o}, 32'd0);
    check("R1 done in reset", {31'd0, done_o}, 32'd0);
    check("R1 product in reset", product_o, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 busy after reset", {31'd0, busy_o}, 32'd0);
    check("R1 done after reset", {31'd0, done_o}, 32'd0);
    check("R1 product after reset", product_o, 32'd0);

    // Sweep: every top-bit position and zero, against several multiplicands.
    for (int p = -1; p < 16; p++) begin
      for (int v = 0; v < 3; v++) begin
        logic [15:0] b;
        if (p < 0) b = 16'd0;
        else if (v == 0) b = 16'd1 << p;
        else if (v == 1) b = 16'((32'd1 << (p + 1)) - 1);
        else begin
          lfsr = step_lfsr(lfsr);
          b = (lfsr & 16'((32'd1 << p) - 1)) | (16'd1 << p);
        end
        for (int k = 0; k < 6; k++) begin
          logic [15:0] a;
          case (k)
            0: a = 16'd0;
            1: a = 16'd1;
            2: a = 16'hFFFF;
            3: a = 16'h8000;
            4: a = 16'hA5A5;
            default: begin lfsr = step_lfsr(lfsr); a = lfsr; end
          endcase
          run_op(b, a, 1'b0);  // next op issued in the done cycle: R9
        end
      end
      idle_check(product_o);
    end

    // R9: explicit back-to-back, start raised in the done cycle.
    run_op(16'h00F3, 16'h1234, 1'b0);
    run_op(16'h0005, 16'h0007, 1'b0);
    check("R9 back-to-back product", product_o, 32'd35);
    idle_check(32'd35);

    // R8: start raised mid-operation is ignored.
    run_op(16'hFFFF, 16'hFFFF, 1'b1);
    idle_check(32'hFFFE0001);
    run_op(16'h0040, 16'h0321, 1'b1);
    idle_check(32'h0000C840);
    run_op(16'h0000, 16'hBEEF, 1'b1);
    idle_check(32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule